// File: doc/BRIEF.md
# EEPROM Command Controller

This block sits between a host register interface and a serial configuration EEPROM. Software drives it through two registers. The data register holds one EEPROM byte. The command register holds a busy bit, a 3-bit operation code, a word address and two status flags. To read a byte, software writes the command with busy set and the read code, then polls until busy drops. The fetched byte is then in the data register. A write works the same way, except that software loads the data register before it issues the command. If the EEPROM does not answer within a bounded number of clock cycles, the block gives up, clears busy and raises a sticky timeout flag. Software clears that flag by writing a one to it.

After reset the block is busy on its own. It reads EEPROM location 0. If that byte carries the signature 0xA5, the block reads locations 1 to 6 into a 48-bit station address and sets a "station address loaded" flag. Software waits for busy to clear before it issues its first command.

The EEPROM wire protocol is abstracted to a request/acknowledge handshake. The block holds `ee_req` high with a stable address, direction and write byte until it sees a one-cycle `ee_ack`. For a read, the byte arrives on `ee_rdata` in that same cycle.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: Command register bit 31 is busy. A host write to the command register, made while idle with bit 31 set and a valid code, sets busy and raises `ee_req`. Busy clears in the same edge that ends the transaction. `ee_req` is never high while busy is low.
- R2: Command bits 30:28 hold the code: 000 is read and 011 is write. They read back as last written. Any other code written with bit 31 set leaves busy at 0 and raises no request.
- R3: A write command drives `ee_we`=1, `ee_wdata` from the data register and `ee_addr` from bits 3:0 of the address field, with the upper address bits forced to 0. A read, and the boot load, drive `ee_we`=0. A read presents the full 8-bit address field (command bits 7:0).
- R4: On a read, the byte returned with `ee_ack` is placed in data register bits 7:0 at the edge that clears busy.
- R5: If `ee_ack` has not arrived by the TIMEOUT_CYC-th cycle of a request, the request drops, busy clears and timeout bit 9 is set. The data register is unchanged. An acknowledge in that last cycle still completes normally.
- R6: Timeout bit 9 is cleared by an idle host write to the command register with bit 9 = 1. Writing 0 there leaves it unchanged.
- R7: While busy, host writes to either register are ignored. This covers data, code, address and the timeout clear.
- R8: Reset leaves the command register at busy = 1 with all other fields 0. The block then reads location 0. If that byte is 0xA5, it reads locations 1..6 into `station_addr`, with location k in bits 8k-1:8k-8. It then sets loaded bit 8 and clears busy.
- R9: If location 0 is not 0xA5, busy clears right after that read, with loaded bit 8 at 0, `station_addr` at 0 and no further request.
- R10: A timeout during the boot load ends it with busy 0, timeout bit 9 set and loaded bit 8 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe, one cycle |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 32 | Host write data |
| cmd_status | output | 32 | Command register readback |
| data_status | output | 8 | Data register readback |
| station_addr | output | 48 | Station address fetched at boot |
| ee_req | output | 1 | EEPROM transaction request, held until acknowledge |
| ee_we | output | 1 | 1 = write transaction, 0 = read |
| ee_addr | output | 8 | EEPROM byte location |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle acknowledge from the EEPROM side |
| ee_rdata | input | 8 | Byte read, valid with ee_ack |

## Verification
The assertions check four cycle-level invariants on every cycle:
- a request is only ever made while busy;
- a write never presents an address above the narrow write field;
- an expired timer always leaves the block idle with the timeout flag set;
- the data register stays frozen during a transaction until the acknowledge.

The loaded flag may only rise off an acknowledged final address byte, and a bad signature returns the block to idle. The bench shows the end-to-end effects that no single-cycle property can:
- the bytes that land in the EEPROM model and in the station address;
- a completion exactly at the last allowed cycle, against an expiry;
- the sticky flag surviving a masked clear during busy.

// File: rtl/eectl_pkg.sv
// Package: shared codes, register bit positions and sequencer states for
// the EEPROM command controller. Assumes a 32-bit host command word.
package eectl_pkg;

    localparam logic [2:0] CODE_READ  = 3'b000;
    localparam logic [2:0] CODE_WRITE = 3'b011;

    localparam int BUSY_BIT   = 31;
    localparam int CODE_HI    = 30;
    localparam int CODE_LO    = 28;
    localparam int TMO_BIT    = 9;
    localparam int LOADED_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_MAC  = 2'd2,
        ST_CMD  = 2'd3
    } eectl_state_e;

endpackage

// File: rtl/eectl_timer.sv
// Module: response timer. Counts the cycles a request has been open and
// flags expiry in the LIMIT-th cycle unless an acknowledge arrives then.
// Assumes LIMIT >= 2 and that ack restarts the count for a follow-on request.
module eectl_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ack_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count open-request cycles, restart on ack or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || ack_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && !ack_i && (cnt_q == CNT_W'(LIMIT - 1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CNT_W'(LIMIT))); // R5

endmodule

// File: rtl/eectl_macbuf.sv
// Module: station address buffer. One byte slot per address byte, each
// written when the sequencer delivers that byte index. Assumes idx_i
// counts from 0 for the lowest byte.
module eectl_macbuf #(
    parameter int NBYTES = 6,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [BYTE_W-1:0]        byte_i,
    output logic [NBYTES*BYTE_W-1:0] addr_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;

        // Purpose: capture byte g when its index is delivered.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_i && (idx_i == IDX_W'(g))) begin
                slot_q <= byte_i;
            end
        end

        assign addr_o[g*BYTE_W +: BYTE_W] = slot_q;
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (idx_i < IDX_W'(NBYTES))); // R8

endmodule

// File: rtl/eectl_core.sv
// Module: command/status registers and transaction sequencer. Runs the
// boot load (signature then address bytes), host reads and writes, and
// the timeout ending. Assumes ADDR_W <= 8 so the address field sits
// below the status flags in the command word.
module eectl_core
    import eectl_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              WR_ADDR_W = 4,
    parameter int              DATA_W    = 8,
    parameter int              MAC_BYTES = 6,
    parameter int              IDX_W     = 3,
    parameter logic [DATA_W-1:0] MAGIC   = 'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_i,
    input  logic              host_sel_i,
    input  logic [31:0]       host_wdata_i,
    input  logic              ee_ack_i,
    input  logic [DATA_W-1:0] ee_rdata_i,
    input  logic              expired_i,
    output logic              ee_req_o,
    output logic              ee_we_o,
    output logic [ADDR_W-1:0] ee_addr_o,
    output logic [DATA_W-1:0] ee_wdata_o,
    output logic [31:0]       cmd_word_o,
    output logic [DATA_W-1:0] data_word_o,
    output logic              mac_we_o,
    output logic [IDX_W-1:0]  mac_idx_o,
    output logic [DATA_W-1:0] mac_byte_o
);
    eectl_state_e      state_q;
    logic              busy_q;
    logic [2:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tmo_q;
    logic              loaded_q;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_q;

    logic       host_ok;
    logic [2:0] new_code;
    logic       cmd_start;
    logic       unused_host;

    assign unused_host = ^host_wdata_i;
    assign host_ok     = host_wr_i && !busy_q;
    assign new_code    = host_wdata_i[CODE_HI:CODE_LO];
    assign cmd_start   = host_ok && !host_sel_i && host_wdata_i[BUSY_BIT]
                         && ((new_code == CODE_READ) || (new_code == CODE_WRITE));

    // Purpose: sequence boot load, host commands and timeout endings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HDR;
            busy_q   <= 1'b1;
            code_q   <= '0;
            addr_q   <= '0;
            tmo_q    <= 1'b0;
            loaded_q <= 1'b0;
            data_q   <= '0;
            idx_q    <= '0;
        end else if ((state_q != ST_IDLE) && expired_i) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            tmo_q   <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (host_ok && !host_sel_i) begin
                        code_q <= new_code;
                        addr_q <= host_wdata_i[ADDR_W-1:0];
                        if (host_wdata_i[TMO_BIT]) begin
                            tmo_q <= 1'b0;
                        end
                        if (cmd_start) begin
                            busy_q  <= 1'b1;
                            state_q <= ST_CMD;
                        end
                    end else if (host_ok && host_sel_i) begin
                        data_q <= host_wdata_i[DATA_W-1:0];
                    end
                end
                ST_HDR: begin
                    if (ee_ack_i) begin
                        if (ee_rdata_i == MAGIC) begin
                            state_q <= ST_MAC;
                            idx_q   <= IDX_W'(1);
                        end else begin
                            state_q <= ST_IDLE;
                            busy_q  <= 1'b0;
                        end
                    end
                end
                ST_MAC: begin
                    if (ee_ack_i) begin
                        if (idx_q == IDX_W'(MAC_BYTES)) begin
                            loaded_q <= 1'b1;
                            state_q  <= ST_IDLE;
                            busy_q   <= 1'b0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_CMD: begin
                    if (ee_ack_i) begin
                        if (code_q == CODE_READ) begin
                            data_q <= ee_rdata_i;
                        end
                        state_q <= ST_IDLE;
                        busy_q  <= 1'b0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    busy_q  <= 1'b0;
                end
            endcase
        end
    end

    assign ee_req_o   = (state_q != ST_IDLE);
    assign ee_we_o    = (state_q == ST_CMD) && (code_q == CODE_WRITE);
    assign ee_wdata_o = data_q;

    // Purpose: pick the EEPROM location for the active transaction.
    always_comb begin
        case (state_q)
            ST_MAC:  ee_addr_o = ADDR_W'(idx_q);
            ST_CMD:  ee_addr_o = (code_q == CODE_WRITE)
                                 ? ADDR_W'(addr_q[WR_ADDR_W-1:0]) : addr_q;
            default: ee_addr_o = '0;
        endcase
    end

    // Purpose: assemble the command register readback word.
    always_comb begin
        cmd_word_o                   = '0;
        cmd_word_o[BUSY_BIT]         = busy_q;
        cmd_word_o[CODE_HI:CODE_LO]  = code_q;
        cmd_word_o[TMO_BIT]          = tmo_q;
        cmd_word_o[LOADED_BIT]       = loaded_q;
        cmd_word_o[ADDR_W-1:0]       = addr_q;
    end

    assign data_word_o = data_q;
    assign mac_we_o    = (state_q == ST_MAC) && ee_ack_i;
    assign mac_idx_o   = idx_q - 1'b1;
    assign mac_byte_o  = ee_rdata_i;

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req_o |-> busy_q); // R1
    AST_WR_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        ee_we_o |-> ((ee_addr_o >> WR_ADDR_W) == '0)); // R3
    AST_EXPIRY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        expired_i |=> (tmo_q && !busy_q && !ee_req_o)); // R5
    AST_BUSY_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ee_ack_i) |=> $stable(data_q)); // R7
    AST_LOADED_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded_q) |-> $past(mac_we_o)); // R8
    AST_BAD_SIGNATURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HDR) && ee_ack_i && (ee_rdata_i != MAGIC))
        |=> (!ee_req_o && !loaded_q)); // R9

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
// Module: top of the EEPROM command controller. Wires the sequencer to
// its response timer and the station address buffer. Assumes the EEPROM
// side acknowledges with a one-cycle pulse carrying read data.
module eeprom_cmd_ctrl #(
    parameter int              ADDR_W      = 8,
    parameter int              WR_ADDR_W   = 4,
    parameter int              DATA_W      = 8,
    parameter int              MAC_BYTES   = 6,
    parameter int              TIMEOUT_CYC = 1024,
    parameter logic [DATA_W-1:0] MAGIC     = 'hA5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_wr,
    input  logic                        host_sel,
    input  logic [31:0]                 host_wdata,
    output logic [31:0]                 cmd_status,
    output logic [DATA_W-1:0]           data_status,
    output logic [MAC_BYTES*DATA_W-1:0] station_addr,
    output logic                        ee_req,
    output logic                        ee_we,
    output logic [ADDR_W-1:0]           ee_addr,
    output logic [DATA_W-1:0]           ee_wdata,
    input  logic                        ee_ack,
    input  logic [DATA_W-1:0]           ee_rdata
);
    localparam int IDX_W = $clog2(MAC_BYTES + 1);

    logic              expired;
    logic              mac_we;
    logic [IDX_W-1:0]  mac_idx;
    logic [DATA_W-1:0] mac_byte;

    eectl_core #(
        .ADDR_W    (ADDR_W),
        .WR_ADDR_W (WR_ADDR_W),
        .DATA_W    (DATA_W),
        .MAC_BYTES (MAC_BYTES),
        .IDX_W     (IDX_W),
        .MAGIC     (MAGIC)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr),
        .host_sel_i   (host_sel),
        .host_wdata_i (host_wdata),
        .ee_ack_i     (ee_ack),
        .ee_rdata_i   (ee_rdata),
        .expired_i    (expired),
        .ee_req_o     (ee_req),
        .ee_we_o      (ee_we),
        .ee_addr_o    (ee_addr),
        .ee_wdata_o   (ee_wdata),
        .cmd_word_o   (cmd_status),
        .data_word_o  (data_status),
        .mac_we_o     (mac_we),
        .mac_idx_o    (mac_idx),
        .mac_byte_o   (mac_byte)
    );

    eectl_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ee_req),
        .ack_i     (ee_ack),
        .expired_o (expired)
    );

    eectl_macbuf #(
        .NBYTES (MAC_BYTES),
        .BYTE_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_macbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mac_we),
        .idx_i  (mac_idx),
        .byte_i (mac_byte),
        .addr_o (station_addr)
    );

endmodule

// File: tb/eeprom_cmd_ctrl_test.sv
module eeprom_cmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_status;
    logic [7:0]  data_status;
    logic [47:0] station_addr;
    logic        ee_req, ee_we;
    logic [7:0]  ee_addr, ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    eeprom_cmd_ctrl #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_status(cmd_status), .data_status(data_status),
        .station_addr(station_addr), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM responder: byte array, programmable ack delay, can go mute.
    logic [7:0] mem [0:255];
    int  ack_delay = 2;
    bit  mute = 1'b0;
    int  wcnt = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ee_ack = 1'b0; wcnt = 0;
        end else if (ee_ack) begin
            ee_ack = 1'b0; wcnt = 0;
        end else if (!ee_req) begin
            wcnt = 0;
        end else if (!mute) begin
            if (wcnt >= ack_delay) begin
                ee_ack = 1'b1;
                ee_rdata = mem[ee_addr];
                if (ee_we) mem[ee_addr] = ee_wdata;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // Behavioural reference model, advanced on every rising edge.
    int          m_phase = 1;   // 0 idle, 1 signature, 2 address bytes, 3 host op
    int          m_idx = 0;
    int          m_wait = 0;
    logic [2:0]  m_code = '0;
    logic [7:0]  m_addr = '0;
    logic        m_to = 1'b0;
    logic        m_loaded = 1'b0;
    logic [7:0]  m_data = '0;
    logic [47:0] m_mac = '0;
    bit          cmp_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 1; m_idx = 0; m_wait = 0; m_code = '0; m_addr = '0;
            m_to = 1'b0; m_loaded = 1'b0; m_data = '0; m_mac = '0; cmp_en = 1'b1;
        end else if (m_phase == 0) begin
            m_wait = 0;
            if (host_wr && !host_sel) begin
                m_code = host_wdata[30:28];
                m_addr = host_wdata[7:0];
                if (host_wdata[9]) m_to = 1'b0;
                if (host_wdata[31] && (m_code == 3'b000 || m_code == 3'b011)) m_phase = 3;
            end else if (host_wr && host_sel) begin
                m_data = host_wdata[7:0];
            end
        end else if (ee_ack) begin
            m_wait = 0;
            if (m_phase == 1) begin
                if (ee_rdata == 8'hA5) begin m_phase = 2; m_idx = 1; end
                else m_phase = 0;
            end else if (m_phase == 2) begin
                m_mac[(m_idx-1)*8 +: 8] = ee_rdata;
                if (m_idx == 6) begin m_loaded = 1'b1; m_phase = 0; end
                else m_idx++;
            end else begin
                if (m_code == 3'b000) m_data = ee_rdata;
                m_phase = 0;
            end
        end else if (m_wait == TMO - 1) begin
            m_to = 1'b1; m_phase = 0; m_wait = 0;
        end else begin
            m_wait++;
        end
    end

    function automatic logic [7:0] exp_addr();
        if (m_phase == 2) return 8'(m_idx);
        if (m_phase == 3) return (m_code == 3'b011) ? {4'b0, m_addr[3:0]} : m_addr;
        return 8'h00;
    endfunction

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R1 busy bit", cmd_status[31], m_phase != 0);
            check("R1 request", ee_req, m_phase != 0);
            check("R2 code field", cmd_status[30:28], m_code);
            check("R2 address field", cmd_status[7:0], m_addr);
            check("R5 timeout bit", cmd_status[9], m_to);
            check("R8 loaded bit", cmd_status[8], m_loaded);
            check("R4 data register", data_status, m_data);
            check("R8 station address", station_addr, m_mac);
            if (m_phase != 0) begin
                check("R3 location", ee_addr, exp_addr());
                check("R3 direction", ee_we, (m_phase == 3) && (m_code == 3'b011));
                if (ee_we) check("R3 write byte", ee_wdata, m_data);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog: run did not end actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic host_write(input logic sel, input logic [31:0] w);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (!cmd_status[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset command word", cmd_status, 32'h8000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        mem[0] = 8'hA5;
        mem[1] = 8'h02; mem[2] = 8'h1B; mem[3] = 8'h3C;
        mem[4] = 8'h4D; mem[5] = 8'h5E; mem[6] = 8'h6F;
        mem[8'h37] = 8'h5C; mem[8'hF3] = 8'h44; mem[8'h20] = 8'hC3; mem[8'h40] = 8'h77;

        // R8: boot load with valid signature
        do_reset();
        check("R8 loaded after boot", cmd_status[8], 1'b1);
        check("R8 station address value", station_addr, 48'h6F5E_4D3C_1B02);
        check("R8 busy cleared after boot", cmd_status[31], 1'b0);

        // R4 / R1: plain read
        host_write(1'b0, 32'h8000_0037);
        check("R1 busy set by command", cmd_status[31], 1'b1);
        wait_idle();
        check("R4 read byte", data_status, 8'h5C);

        // R3: write uses low 4 address bits only
        host_write(1'b1, 32'h0000_009E);
        host_write(1'b0, 32'hB000_00F3);
        wait_idle();
        check("R3 narrow write location", mem[3], 8'h9E);
        check("R3 wide location untouched", mem[8'hF3], 8'h44);

        // R5 boundary: ack in the last allowed cycle
        ack_delay = TMO - 1;
        host_write(1'b0, 32'h8000_0020);
        wait_idle();
        check("R5 last-cycle ack no timeout", cmd_status[9], 1'b0);
        check("R5 last-cycle ack data", data_status, 8'hC3);

        // R5: no response at all
        mute = 1'b1;
        host_write(1'b0, 32'h8000_0021);
        wait_idle();
        check("R5 timeout flag", cmd_status[9], 1'b1);
        check("R5 data unchanged", data_status, 8'hC3);
        check("R5 request dropped", ee_req, 1'b0);
        mute = 1'b0;

        // R7: writes during busy are ignored
        ack_delay = 10;
        host_write(1'b0, 32'h8000_0040);
        host_write(1'b1, 32'h0000_0011);
        host_write(1'b0, 32'hB000_0205);
        wait_idle();
        check("R7 data not overwritten", data_status, 8'h77);
        check("R7 timeout clear ignored", cmd_status[9], 1'b1);
        check("R7 fields unchanged", cmd_status[7:0], 8'h40);

        // R6: write-one-to-clear
        ack_delay = 1;
        host_write(1'b0, 32'h0000_0040);
        check("R6 zero keeps flag", cmd_status[9], 1'b1);
        host_write(1'b0, 32'h0000_0240);
        check("R6 one clears flag", cmd_status[9], 1'b0);

        // R2: unsupported code does nothing
        host_write(1'b0, 32'hD000_0012);
        check("R2 unknown code stays idle", cmd_status[31], 1'b0);
        check("R2 unknown code no request", ee_req, 1'b0);
        check("R2 code readback", cmd_status[30:28], 3'b101);

        // R9: bad signature
        mem[0] = 8'h5A;
        do_reset();
        check("R9 loaded stays 0", cmd_status[8], 1'b0);
        check("R9 station address 0", station_addr, 48'h0);
        check("R9 no request", ee_req, 1'b0);

        // R10: EEPROM silent during boot
        mem[0] = 8'hA5;
        mute = 1'b1;
        do_reset();
        check("R10 boot timeout flag", cmd_status[9], 1'b1);
        check("R10 loaded stays 0", cmd_status[8], 1'b0);
        check("R10 busy cleared", cmd_status[31], 1'b0);
        mute = 1'b0;

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule